// File: doc/BRIEF.md
# Runahead Invalid-Bit Propagation Unit

This block controls a speculative runahead episode in an out-of-order core. When the oldest load in flight misses in the second-level cache, the unit requests a checkpoint of the architectural state in that same cycle and switches to runahead mode. In runahead mode the core keeps fetching and executing past the stalled load, so that later loads act as prefetches. The block does not hold any data. It keeps one poison bit per architectural register to mark which register values are bogus.

The missing load's destination register is poisoned. Every later instruction that reads a poisoned source poisons its own destination. An instruction whose used sources are all clean makes its destination clean again. A branch that reads a poisoned source cannot be resolved, so it is flagged and follows its predicted direction. A further miss during runahead only poisons that load's destination and does not start a new checkpoint. When the missing data returns, the block issues a restore pulse, clears every poison bit and goes back to normal mode.

The core drives one renamed instruction per cycle: two source indices, each with a use flag, a destination index with a write flag, and a branch flag. It also drives the miss and fill-return events. The block reports the current mode, the checkpoint and restore pulses, the poison verdict for the current instruction and the full poison vector.

Top module: `runahead_poison_unit`

## Requirements
- R1: After reset the unit is in normal mode: `runahead_o` is 0, no pulse is asserted and all poison bits are 0.
- R2: In normal mode, `miss_vld_i` together with `miss_oldest_i` asserts `ckpt_take_o` in the same cycle. From the next cycle the unit is in runahead mode, and the bit selected by `miss_dst_i` is set.
- R3: In normal mode, a miss with `miss_oldest_i` low has no effect: no checkpoint is taken, the mode stays normal and the poison vector stays 0.
- R4: In runahead mode, a valid instruction with at least one used source whose poison bit is 1 drives `inst_inv_o` high in the same cycle. If `dst_wr_i` is 1, the bit at `dst_i` is 1 from the next cycle.
- R5: In runahead mode, a valid instruction with `dst_wr_i` high whose used sources are all clean clears the bit at `dst_i`. A source whose use flag is 0 is never consulted.
- R6: In runahead mode, a valid instruction with `is_branch_i` high and a poisoned used source drives `br_unresolved_o` high in that cycle. This output is 0 in all other cases.
- R7: A miss during runahead, whether or not it is the oldest, never asserts `ckpt_take_o`. It sets the poison bit at `miss_dst_i` for the next cycle.
- R8: `fill_ret_i` in runahead mode asserts `ckpt_restore_o` in that cycle. From the next cycle the mode is normal and all poison bits are 0. `fill_ret_i` in normal mode has no effect.
- R9: In the same cycle, a fill return overrides every other update. A miss to register d overrides an instruction write of d, so the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_vld_i | input | 1 | A load missed in the second-level cache this cycle |
| miss_oldest_i | input | 1 | The missing load is the oldest instruction in flight |
| miss_dst_i | input | 5 | Destination register of the missing load |
| fill_ret_i | input | 1 | Data for the miss that started the episode has returned |
| inst_vld_i | input | 1 | An instruction is presented this cycle |
| src1_i | input | 5 | First source register |
| src1_use_i | input | 1 | First source is read |
| src2_i | input | 5 | Second source register |
| src2_use_i | input | 1 | Second source is read |
| dst_i | input | 5 | Destination register |
| dst_wr_i | input | 1 | The instruction writes `dst_i` |
| is_branch_i | input | 1 | The instruction is a branch |
| runahead_o | output | 1 | Unit is in runahead mode |
| ckpt_take_o | output | 1 | One-cycle request to take a checkpoint |
| ckpt_restore_o | output | 1 | One-cycle request to restore the checkpoint |
| inst_inv_o | output | 1 | Current instruction produces a poisoned result |
| br_unresolved_o | output | 1 | Current branch cannot be resolved |
| inv_bits_o | output | 32 | Poison bit of each architectural register |

## Verification
The bench aims at the cycles where events collide. One case is a fill return together with a miss or an instruction write: a design that let either one survive would leave a stale poison bit after the restore. Another is a miss and an instruction targeting the same register in the same cycle: a design that got the priority backwards would clear a bit that should stay set. The bench also sends second misses during runahead, where an extra `ckpt_take_o` would indicate a nested checkpoint. Finally, it presents instructions whose poisoned register sits on a source with its use flag low. A design that ignored the use flags would over-poison and flag branches it should resolve.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic {
    RP_NORMAL   = 1'b0,
    RP_RUNAHEAD = 1'b1
  } rp_mode_e;
endpackage

// File: rtl/rp_mode_ctrl.sv
module rp_mode_ctrl
  import rp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_vld_i,
  input  logic miss_oldest_i,
  input  logic fill_ret_i,
  output logic runahead_o,
  output logic enter_o,
  output logic leave_o
);
  rp_mode_e mode_q, mode_d;
  logic     mode_en;

  always_comb begin
    enter_o = (mode_q == RP_NORMAL) && miss_vld_i && miss_oldest_i;
    leave_o = (mode_q == RP_RUNAHEAD) && fill_ret_i;
    mode_d  = mode_q;
    if (enter_o) mode_d = RP_RUNAHEAD;
    if (leave_o) mode_d = RP_NORMAL;
    mode_en = enter_o || leave_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RP_NORMAL;
    else if (mode_en) mode_q <= mode_d;
  end

  assign runahead_o = (mode_q == RP_RUNAHEAD);
endmodule

// File: rtl/rp_poison_file.sv
module rp_poison_file #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             miss_set_i,
  input  logic [AW-1:0]    miss_idx_i,
  input  logic             upd_i,
  input  logic [AW-1:0]    upd_idx_i,
  input  logic             upd_val_i,
  output logic [NREGS-1:0] bits_o
);
  logic [NREGS-1:0] bits_q;
  logic [NREGS-1:0] bits_d;
  logic [NREGS-1:0] bit_en;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic miss_hit;
    logic upd_hit;

    always_comb begin
      miss_hit  = miss_set_i && (miss_idx_i == AW'(g));
      upd_hit   = upd_i && (upd_idx_i == AW'(g));
      bit_en[g] = clr_i || miss_hit || upd_hit;
      if (clr_i)         bits_d[g] = 1'b0;
      else if (miss_hit) bits_d[g] = 1'b1;
      else               bits_d[g] = upd_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bits_q[g] <= 1'b0;
      else if (bit_en[g]) bits_q[g] <= bits_d[g];
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/rp_src_lookup.sv
module rp_src_lookup #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] bits_i,
  input  logic [AW-1:0]    src1_i,
  input  logic             src1_use_i,
  input  logic [AW-1:0]    src2_i,
  input  logic             src2_use_i,
  output logic             any_inv_o
);
  logic hit1;
  logic hit2;

  always_comb begin
    hit1      = src1_use_i && bits_i[src1_i];
    hit2      = src2_use_i && bits_i[src2_i];
    any_inv_o = hit1 || hit2;
  end
endmodule

// File: rtl/runahead_poison_unit.sv
module runahead_poison_unit #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_vld_i,
  input  logic             miss_oldest_i,
  input  logic [AW-1:0]    miss_dst_i,
  input  logic             fill_ret_i,
  input  logic             inst_vld_i,
  input  logic [AW-1:0]    src1_i,
  input  logic             src1_use_i,
  input  logic [AW-1:0]    src2_i,
  input  logic             src2_use_i,
  input  logic [AW-1:0]    dst_i,
  input  logic             dst_wr_i,
  input  logic             is_branch_i,
  output logic             runahead_o,
  output logic             ckpt_take_o,
  output logic             ckpt_restore_o,
  output logic             inst_inv_o,
  output logic             br_unresolved_o,
  output logic [NREGS-1:0] inv_bits_o
);
  logic enter;
  logic leave;
  logic in_ra;
  logic src_inv;
  logic miss_set;
  logic inst_upd;
  logic inst_act;

  rp_mode_ctrl u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_vld_i    (miss_vld_i),
    .miss_oldest_i (miss_oldest_i),
    .fill_ret_i    (fill_ret_i),
    .runahead_o    (in_ra),
    .enter_o       (enter),
    .leave_o       (leave)
  );

  rp_src_lookup #(.NREGS(NREGS)) u_lookup (
    .bits_i     (inv_bits_o),
    .src1_i     (src1_i),
    .src1_use_i (src1_use_i),
    .src2_i     (src2_i),
    .src2_use_i (src2_use_i),
    .any_inv_o  (src_inv)
  );

  always_comb begin
    inst_act = in_ra && inst_vld_i;
    inst_upd = inst_act && dst_wr_i;
    miss_set = enter || (in_ra && miss_vld_i);
  end

  rp_poison_file #(.NREGS(NREGS)) u_poison (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (leave),
    .miss_set_i (miss_set),
    .miss_idx_i (miss_dst_i),
    .upd_i      (inst_upd),
    .upd_idx_i  (dst_i),
    .upd_val_i  (src_inv),
    .bits_o     (inv_bits_o)
  );

  assign runahead_o      = in_ra;
  assign ckpt_take_o     = enter;
  assign ckpt_restore_o  = leave;
  assign inst_inv_o      = inst_act && src_inv;
  assign br_unresolved_o = inst_act && is_branch_i && src_inv;
endmodule

// File: rtl/runahead_poison_unit_chk.sv
module runahead_poison_unit_chk #(
  parameter int NREGS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_ret_i,
  input logic             runahead_o,
  input logic             ckpt_take_o,
  input logic             ckpt_restore_o,
  input logic             br_unresolved_o,
  input logic [NREGS-1:0] inv_bits_o
);
  // R1, R8: in normal mode no register may carry a poison bit
  p_normal_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !runahead_o |-> (inv_bits_o == '0));

  // R2: a checkpoint request is followed by runahead mode
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_take_o |=> runahead_o);

  // R7: no checkpoint is requested while already in runahead
  p_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runahead_o |-> !ckpt_take_o);

  // R8: a restore returns the unit to a clean normal mode
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore_o |=> (!runahead_o && inv_bits_o == '0));

  // R8: a restore is only issued in runahead when the fill arrives
  p_restore_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore_o |-> (runahead_o && fill_ret_i));

  // R6: unresolved branches exist only in runahead
  p_unres_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_unresolved_o |-> runahead_o);
endmodule

bind runahead_poison_unit runahead_poison_unit_chk #(.NREGS(NREGS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fill_ret_i      (fill_ret_i),
  .runahead_o      (runahead_o),
  .ckpt_take_o     (ckpt_take_o),
  .ckpt_restore_o  (ckpt_restore_o),
  .br_unresolved_o (br_unresolved_o),
  .inv_bits_o      (inv_bits_o)
);

// File: tb/runahead_poison_unit_tb.sv
module runahead_poison_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_vld_i, miss_oldest_i, fill_ret_i;
  logic [4:0]  miss_dst_i;
  logic        inst_vld_i, src1_use_i, src2_use_i, dst_wr_i, is_branch_i;
  logic [4:0]  src1_i, src2_i, dst_i;
  logic        runahead_o, ckpt_take_o, ckpt_restore_o, inst_inv_o, br_unresolved_o;
  logic [31:0] inv_bits_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  bit        m_ra;
  bit [31:0] m_p;

  always #2.5 clk = ~clk;

  runahead_poison_unit u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic drive_idle();
    miss_vld_i = 0; miss_oldest_i = 0; miss_dst_i = 0; fill_ret_i = 0;
    inst_vld_i = 0; src1_i = 0; src1_use_i = 0; src2_i = 0; src2_use_i = 0;
    dst_i = 0; dst_wr_i = 0; is_branch_i = 0;
  endtask

  // compare outputs with the model, then advance the model one cycle
  task automatic step_and_check();
    bit take, rest, sinv;
    #1;
    take = !m_ra && miss_vld_i && miss_oldest_i;
    rest = m_ra && fill_ret_i;
    sinv = (src1_use_i && m_p[src1_i]) || (src2_use_i && m_p[src2_i]);
    chk("R1/R2/R3 runahead_o", 32'(runahead_o), 32'(m_ra));
    chk("R2/R7 ckpt_take_o", 32'(ckpt_take_o), 32'(take));
    chk("R8 ckpt_restore_o", 32'(ckpt_restore_o), 32'(rest));
    chk("R4/R5 inst_inv_o", 32'(inst_inv_o), 32'(m_ra && inst_vld_i && sinv));
    chk("R6 br_unresolved_o", 32'(br_unresolved_o), 32'(m_ra && inst_vld_i && is_branch_i && sinv));
    chk("R4/R5/R7/R9 inv_bits_o", inv_bits_o, m_p);
    if (rest) begin
      m_p = '0; m_ra = 0;
    end else begin
      if (m_ra && inst_vld_i && dst_wr_i) m_p[dst_i] = sinv;
      if (take || (m_ra && miss_vld_i)) m_p[miss_dst_i] = 1'b1;
      if (take) m_ra = 1;
    end
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    drive_idle();
    rst_n = 0;
    m_ra = 0; m_p = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset runahead_o", 32'(runahead_o), 32'd0);
    chk("R1 reset inv_bits_o", inv_bits_o, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R3: non-oldest miss in normal mode
    drive_idle(); miss_vld_i = 1; miss_dst_i = 5'd7; step_and_check();
    // R8: fill in normal mode ignored
    drive_idle(); fill_ret_i = 1; step_and_check();
    // R2: enter on oldest miss to r3
    drive_idle(); miss_vld_i = 1; miss_oldest_i = 1; miss_dst_i = 5'd3; step_and_check();
    // R4: r3 -> r9 via src2
    drive_idle(); inst_vld_i = 1; src2_i = 5'd3; src2_use_i = 1; dst_i = 5'd9; dst_wr_i = 1; step_and_check();
    // R5: unused poisoned source ignored, clean r9? no: r10 from r3 unused
    drive_idle(); inst_vld_i = 1; src1_i = 5'd3; src2_i = 5'd1; src2_use_i = 1; dst_i = 5'd10; dst_wr_i = 1; is_branch_i = 1; step_and_check();
    // R6: branch on poisoned r9
    drive_idle(); inst_vld_i = 1; src1_i = 5'd9; src1_use_i = 1; is_branch_i = 1; step_and_check();
    // R5: overwrite r9 with clean value
    drive_idle(); inst_vld_i = 1; src1_i = 5'd2; src1_use_i = 1; dst_i = 5'd9; dst_wr_i = 1; step_and_check();
    // R7 + R9: second oldest miss to r12 while instruction writes r12 clean
    drive_idle(); miss_vld_i = 1; miss_oldest_i = 1; miss_dst_i = 5'd12;
    inst_vld_i = 1; dst_i = 5'd12; dst_wr_i = 1; step_and_check();
    // R8 + R9: fill with competing miss and poisoning write
    drive_idle(); fill_ret_i = 1; miss_vld_i = 1; miss_dst_i = 5'd20;
    inst_vld_i = 1; src1_i = 5'd3; src1_use_i = 1; dst_i = 5'd21; dst_wr_i = 1; step_and_check();
    // R8: clean normal mode afterwards
    drive_idle(); step_and_check();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      drive_idle();
      miss_vld_i    = ($urandom_range(0, 9) == 0);
      miss_oldest_i = $urandom_range(0, 1);
      miss_dst_i    = 5'($urandom);
      fill_ret_i    = ($urandom_range(0, 24) == 0);
      inst_vld_i    = ($urandom_range(0, 3) != 0);
      src1_i        = 5'($urandom_range(0, 7));
      src2_i        = 5'($urandom_range(0, 7));
      src1_use_i    = $urandom_range(0, 1);
      src2_use_i    = $urandom_range(0, 1);
      dst_i         = 5'($urandom_range(0, 7));
      dst_wr_i      = ($urandom_range(0, 3) != 0);
      is_branch_i   = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 1) == 1) miss_dst_i = 5'($urandom_range(0, 7));
      step_and_check();
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule